// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up a 24-channel digital input port before software or neighbouring logic sees it. Each raw input is brought into the clock domain by a two-flop synchronizer. From there it either goes straight to the output, or it passes through a stability filter that lets a new level through only after the level has held for one whole filter period. Every channel has its own enable bit. All channels share one programmable period, and a prescaled timebase turns that period into clock cycles.

A byte-wide register port sets up the block. The period is a 20-bit count of timebase units. The channel enables form a 24-bit mask. A write-only clear register carries two strobes: one restarts the period timing, and the other loads each filtered channel with its current synchronized input. The same address port reads back the filtered port as three bytes. A filtered channel updates only at period boundaries, so the delay from an input edge to the output is between one and two periods. Any pulse shorter than one period never reaches the output.

Top module: `glitch_filter`

## Requirements
- R1: While rst_ni is low, and directly after it rises, dout_o and rdata_o are 0. Every channel enable and the period value reset to 0, so all inputs start unfiltered.
- R2: A channel whose enable bit is 0 shows din_i on dout_o two clock edges after din_i is sampled: once through each synchronizer flop.
- R3: Let P = max(V,1) x UNIT_CYCLES clock cycles. For an enabled channel, dout_o changes only at a period boundary, and only when the synchronized input held one level for the whole period before that boundary. If the new level is already synchronized when a restart is written, the channel shows it exactly P cycles after the restart edge.
- R4: A pulse on an enabled channel that is shorter than P cycles never appears on dout_o, whatever its phase. A pulse longer than 2P+1 cycles does appear.
- R5: A period value of 0 acts as a value of 1, so P = UNIT_CYCLES.
- R6: The period value V is written little-endian at address 0x08 (bits 7:0), 0x09 (bits 15:8) and 0x0A (bits 19:16). Only bits 3:0 of the byte at 0x0A are kept.
- R7: The enable mask is written at address 0x0C (channels 7:0), 0x0D (channels 15:8) and 0x0E (channels 23:16). Bit n enables the filter on channel n.
- R8: Writing address 0x07 with bit 0 set restarts the prescaler and the period counter. The next boundary then falls P cycles after that write edge.
- R9: Writing address 0x07 with bit 1 set loads every filtered channel with its current synchronized input on that edge. The clear register itself stores nothing.
- R10: Reading address k (0 to 2) gives dout_o bits 8k+7 down to 8k. Every other address, including 0x07 and the configuration addresses, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; the timebase is derived from it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| din_i | input | 24 | Raw asynchronous inputs |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address for writes and reads |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (filtered port bytes) |
| dout_o | output | 24 | Filtered (or bypassed) inputs |

## Verification
The bench keeps the default port and period widths but builds the block with UNIT_CYCLES set to 4. This makes one period only 4 to 20 clocks long. With periods that short, the bench can sweep every programmed value from 0 to 5 against several enable masks. It can also slide short and long pulses across every phase of a period. One 256-unit value, assembled from the middle byte, and a masked top byte check the byte assembly without making the run long.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] PORT_BASE = 5'h00;
  localparam logic [ADDR_W-1:0] CLR_ADDR  = 5'h07;
  localparam logic [ADDR_W-1:0] IV_BASE   = 5'h08;
  localparam logic [ADDR_W-1:0] EN_BASE   = 5'h0C;
  localparam int CLR_RESTART_BIT = 0;
  localparam int CLR_FLUSH_BIT   = 1;
endpackage

// File: rtl/gf_regs.sv
module gf_regs
  import gf_pkg::*;
#(
  parameter int N_BYTES = 3,
  parameter int IV_W    = 20
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  output logic [IV_W-1:0]       interval_o,
  output logic [N_BYTES*8-1:0]  enable_o,
  output logic                  restart_o,
  output logic                  flush_o
);
  localparam int N_CH     = N_BYTES * 8;
  localparam int IV_BYTES = (IV_W + 7) / 8;

  logic [IV_W-1:0] iv_q;
  logic [N_CH-1:0] en_q;

  for (genvar b = 0; b < IV_BYTES; b++) begin : g_iv
    localparam int BW = ((IV_W - 8*b) < 8) ? (IV_W - 8*b) : 8;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) iv_q[b*8 +: BW] <= '0;
      else if (wr_i && addr_i == IV_BASE + ADDR_W'(b)) iv_q[b*8 +: BW] <= wdata_i[BW-1:0];
    end
  end

  for (genvar b = 0; b < N_BYTES; b++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[b*8 +: 8] <= '0;
      else if (wr_i && addr_i == EN_BASE + ADDR_W'(b)) en_q[b*8 +: 8] <= wdata_i;
    end
  end

  // clear strobes: single-cycle, nothing stored
  assign restart_o  = wr_i && (addr_i == CLR_ADDR) && wdata_i[CLR_RESTART_BIT];
  assign flush_o    = wr_i && (addr_i == CLR_ADDR) && wdata_i[CLR_FLUSH_BIT];
  assign interval_o = iv_q;
  assign enable_o   = en_q;

  // R7
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_q));
  // R6
  iv_clr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == CLR_ADDR) |=> $stable(iv_q));
endmodule

// File: rtl/gf_timebase.sv
module gf_timebase #(
  parameter int IV_W        = 20,
  parameter int UNIT_CYCLES = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IV_W-1:0] interval_i,
  input  logic            restart_i,
  output logic            period_end_o
);
  localparam int PRE_W = $clog2(UNIT_CYCLES + 1);

  logic [PRE_W-1:0] pre_q;
  logic [IV_W-1:0]  cnt_q;
  logic [IV_W-1:0]  lim_m1;
  logic             unit_tick;
  logic             wrap;

  // zero interval behaves as one unit
  assign lim_m1     = (interval_i == '0) ? '0 : interval_i - 1'b1;
  assign unit_tick  = (pre_q == PRE_W'(UNIT_CYCLES - 1));
  assign wrap       = (cnt_q >= lim_m1);
  assign period_end_o = unit_tick && wrap && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (restart_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (unit_tick) begin
      pre_q <= '0;
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R8
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pre_q == '0 && cnt_q == '0));
  // R3
  boundary_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |=> (pre_q == '0 && cnt_q == '0));
  // R5
  zero_iv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_i == '0 && $past(interval_i) == '0 && $past(unit_tick)) |-> cnt_q == '0);
endmodule

// File: rtl/gf_chan.sv
module gf_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  input  logic en_i,
  input  logic period_end_i,
  input  logic restart_i,
  input  logic flush_i,
  output logic dout_o
);
  logic [1:0] sync_q;
  logic       s;
  logic       held_q;
  logic       dirty_q;
  logic       filt_q;

  assign s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      held_q  <= 1'b0;
      dirty_q <= 1'b0;
      filt_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], din_i};
      if (!en_i || flush_i) begin
        filt_q  <= s;
        held_q  <= s;
        dirty_q <= 1'b0;
      end else if (restart_i) begin
        held_q  <= s;
        dirty_q <= 1'b0;
      end else if (period_end_i) begin
        if (!dirty_q && s == held_q) filt_q <= held_q;
        held_q  <= s;
        dirty_q <= 1'b0;
      end else if (s != held_q) begin
        dirty_q <= 1'b1;
      end
    end
  end

  assign dout_o = en_i ? filt_q : s;

  // R3
  no_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !flush_i && !period_end_i) |=> $stable(filt_q));
  // R4
  glitch_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !flush_i && !restart_i && period_end_i && dirty_q) |=> $stable(filt_q));
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import gf_pkg::*;
#(
  parameter int N_BYTES     = 3,
  parameter int IV_W        = 20,
  parameter int UNIT_CYCLES = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_BYTES*8-1:0] din_i,
  input  logic                 wr_i,
  input  logic [4:0]           addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic [N_BYTES*8-1:0] dout_o
);
  localparam int N_CH = N_BYTES * 8;

  logic [IV_W-1:0] interval;
  logic [N_CH-1:0] enable;
  logic            restart;
  logic            flush;
  logic            period_end;

  gf_regs #(.N_BYTES(N_BYTES), .IV_W(IV_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .interval_o(interval), .enable_o(enable),
    .restart_o(restart), .flush_o(flush)
  );

  gf_timebase #(.IV_W(IV_W), .UNIT_CYCLES(UNIT_CYCLES)) u_tb (
    .clk_i, .rst_ni, .interval_i(interval), .restart_i(restart),
    .period_end_o(period_end)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    gf_chan u_ch (
      .clk_i, .rst_ni,
      .din_i(din_i[c]), .en_i(enable[c]),
      .period_end_i(period_end), .restart_i(restart), .flush_i(flush),
      .dout_o(dout_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < N_BYTES; b++)
      if (addr_i == PORT_BASE + ADDR_W'(b)) rdata_o = dout_o[b*8 +: 8];
  end

  // R10
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= ADDR_W'(N_BYTES)) |-> rdata_o == 8'h00);
endmodule

// File: tb/tb_glitch_filter.sv
module tb_glitch_filter;
  localparam int UNIT = 4;
  localparam logic [23:0] ONES = 24'hFFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] din = '0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] dout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  glitch_filter #(.N_BYTES(3), .IV_W(20), .UNIT_CYCLES(UNIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .dout_o(dout)
  );

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick(1);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic set_iv(input int v);
    wreg(5'h08, v[7:0]);
    wreg(5'h09, v[15:8]);
    wreg(5'h0A, {4'h0, v[19:16]});
  endtask

  task automatic set_en(input logic [23:0] m);
    wreg(5'h0C, m[7:0]);
    wreg(5'h0D, m[15:8]);
    wreg(5'h0E, m[23:16]);
  endtask

  // rising step on all channels, restart after sync settles, expect filtered
  // channels exactly p cycles after the restart edge
  task automatic step_test(input int p, input logic [23:0] m, input string tag);
    din = '0; tick(3);
    wreg(5'h07, 8'h02);
    din = ONES; tick(3);
    wreg(5'h07, 8'h01);
    tick(p - 1);
    check(tag, dout, ~m);
    tick(1);
    check(tag, dout, ONES);
  endtask

  // pulse on all-enabled port; returns whether output ever went high
  task automatic pulse_run(input int p, input int off, input int len, output bit seen);
    seen = 0;
    din = '0; tick(3);
    wreg(5'h07, 8'h02);
    wreg(5'h07, 8'h01);
    tick(off);
    din = ONES;
    for (int i = 0; i < len; i++) begin tick(1); if (dout != '0) seen = 1; end
    din = '0;
    for (int i = 0; i < 3*p + 4; i++) begin tick(1); if (dout != '0) seen = 1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [23:0] masks [3];
    int ivs [6];
    bit seen;
    masks[0] = 24'h00FF0F; masks[1] = 24'hF000A5; masks[2] = ONES;
    ivs[0] = 0; ivs[1] = 1; ivs[2] = 2; ivs[3] = 3; ivs[4] = 5; ivs[5] = 4;

    // R1: reset state
    din = 24'h5A5A5A;
    tick(3);
    check("R1", dout, 24'h0);
    check("R1", {16'h0, rdata}, 24'h0);
    @(negedge clk); rst_n = 1'b1; @(posedge clk); #1;
    // R2: unfiltered after reset, two-edge latency
    check("R2", dout, 24'h0);
    tick(1);
    check("R2", dout, 24'h5A5A5A);
    din = 24'hC3_0F_96; tick(1);
    check("R2", dout, 24'h5A5A5A);
    tick(1);
    check("R2", dout, 24'hC3_0F_96);

    // R10: readback over the whole address space
    din = 24'h3C7E91; tick(3);
    for (int a = 0; a < 32; a++) begin
      logic [7:0] e;
      addr = 5'(a); #1;
      e = (a < 3) ? din[a*8 +: 8] : 8'h00;
      check("R10", {16'h0, rdata}, {16'h0, e});
    end
    addr = '0;

    // R3 R5 R7 R8: sweep of period values and enable masks
    for (int mi = 0; mi < 3; mi++) begin
      set_en(masks[mi]);
      for (int k = 0; k < 6; k++) begin
        set_iv(ivs[k]);
        step_test(((ivs[k] == 0) ? 1 : ivs[k]) * UNIT, masks[mi],
                  (ivs[k] == 0) ? "R5" : "R3/R7/R8");
      end
    end

    // R6: upper nibble of top byte ignored -> value 2
    set_en(ONES);
    wreg(5'h08, 8'h02); wreg(5'h09, 8'h00); wreg(5'h0A, 8'hF0);
    step_test(2 * UNIT, ONES, "R6");
    // R6: middle byte -> value 256
    wreg(5'h08, 8'h00); wreg(5'h09, 8'h01); wreg(5'h0A, 8'h00);
    step_test(256 * UNIT, ONES, "R6");

    // R4: short pulses at every phase are suppressed; long ones pass
    set_iv(5);
    for (int off = 0; off < 5*UNIT; off++) begin
      pulse_run(5*UNIT, off, 1, seen);
      check("R4", {23'h0, seen}, 24'h0);
      pulse_run(5*UNIT, off, 5*UNIT - 1, seen);
      check("R4", {23'h0, seen}, 24'h0);
    end
    for (int off = 0; off < 5*UNIT; off += 7) begin
      pulse_run(5*UNIT, off, 10*UNIT + 2, seen);
      check("R4", {23'h0, seen}, 24'h1);
    end

    // R9: flush loads synchronized input at once
    set_iv(1000);
    din = '0; tick(3);
    wreg(5'h07, 8'h02);
    wreg(5'h07, 8'h01);
    din = 24'hABCDEF; tick(3);
    check("R9", dout, 24'h0);
    wreg(5'h07, 8'h02);
    check("R9", dout, 24'hABCDEF);
    addr = 5'h07; #1;
    check("R9", {16'h0, rdata}, 24'h0);
    addr = '0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule